// File: doc/BRIEF.md
# DMA Channel Register File

This block is the programming front end of a multi-channel DMA controller. Each channel keeps a 16-bit start address and a 16-bit transfer count. Software reaches them through byte-wide I/O ports, so every 16-bit value is loaded or read as two bytes. A single byte pointer flip-flop, shared by all register ports, decides whether the next byte goes to the low or the high half. A master-clear strobe and a mask-reset strobe drive the per-channel mask bits. The master clear also puts the byte pointer back to the low half.

Each port offset selects one register. Bit 0 of the offset chooses between count and address, and bits 2:1 choose the channel. A strobe to a register port moves the byte pointer whether it is a read or a write. A mixed read/write sequence therefore changes which half the next access reaches. A write to any other offset that is not one of the two control strobes is accepted and has no effect.

Top module: `dma_chan_regfile`

## Requirements
- R1: After a synchronous active-low reset, every address and count register is zero, the byte pointer selects the low byte and all four mask outputs are 1 (`chan_mask` = 4'hF).
- R2: Port offsets 0 to 7 reach the register file: offset bits 2:1 give the channel number and offset bit 0 selects count (1) or address (0).
- R3: After a pointer reset, the first register-port access reaches bits 7:0 and the second reaches bits 15:8, alternating from then on.
- R4: Reads and writes move the same single byte pointer, whatever the channel or register, so a read after an odd number of writes returns the high byte.
- R5: While `rd_en` is high with a register-port offset, `rd_data` shows the selected byte in that same cycle. The pointer changes at the clock edge that ends the strobe.
- R6: A write to offset 0xD returns the byte pointer to low and sets all mask bits to 1. Address and count contents are kept.
- R7: A write to offset 0xE clears all mask bits to 0 and leaves the byte pointer unchanged.
- R8: Writes to offsets 0x8 to 0xC and 0xF change no register, no mask bit and not the byte pointer.
- R9: If `rd_en` and `wr_en` are high together on a register port, the write is stored and `rd_data` shows the byte held before the write. The pointer moves only once.
- R10: A read of an offset from 0x8 to 0xF returns 8'h00 and does not move the pointer. `rd_data` is 8'h00 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one access per high cycle |
| rd_en | input | 1 | Read strobe, one access per high cycle |
| port_addr | input | 4 | Port offset of the access |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Byte read, valid in the strobe cycle |
| chan_mask | output | 4 | Per-channel mask bits |

## Verification
A read and a write can hit a register port in the same cycle. Both act on the one byte pointer, and the read sees the write's target before it changes. The bench forces this collision on purpose. It expects the read to return the old byte, the new byte to be stored, and the pointer to advance by exactly one step. This is judged by the bytes that later reads return. Random mixes of reads and writes also produce these collisions next to control strobes. A bench model tracks the pointer and every register and predicts each read byte.

// File: rtl/dma_rf_pkg.sv
// Package: shared widths and the per-channel register record used by the
// DMA register file. Assumes a register is exactly two bytes wide.
package dma_rf_pkg;
    localparam int BYTE_W = 8;
    localparam int REG_W  = 2 * BYTE_W;

    typedef struct packed {
        logic [REG_W-1:0] addr;
        logic [REG_W-1:0] cnt;
    } chan_regs_t;
endpackage

// File: rtl/dma_byte_ptr.sv
// Module: shared low/high byte pointer. A step toggles it; a clear forces it
// low and wins over a step in the same cycle. Assumes one access per cycle.
module dma_byte_ptr (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic clear,
    output logic hi_q
);
    // Pointer flip-flop: reset/clear to low, otherwise toggle on a step.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) hi_q <= 1'b0;
        else if (step)       hi_q <= ~hi_q;
    end

    p_ptr_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear) |=> (hi_q != $past(hi_q)));
    p_ptr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !hi_q);
    p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(hi_q));
endmodule

// File: rtl/dma_chan_regs.sv
// Module: one channel's address and count registers, loaded a byte at a time.
// Assumes the caller decodes the channel and supplies the byte half to load.
module dma_chan_regs
    import dma_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              sel_cnt,
    input  logic              hi_byte,
    input  logic [BYTE_W-1:0] wdata,
    output chan_regs_t        regs_q
);
    // Register storage: zero on reset, load the selected byte of one register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (wr_stb) begin
            if (sel_cnt) begin
                if (hi_byte) regs_q.cnt[REG_W-1:BYTE_W]  <= wdata;
                else         regs_q.cnt[BYTE_W-1:0]      <= wdata;
            end else begin
                if (hi_byte) regs_q.addr[REG_W-1:BYTE_W] <= wdata;
                else         regs_q.addr[BYTE_W-1:0]     <= wdata;
            end
        end
    end

    p_regs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(regs_q));
    p_other_reg_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && sel_cnt) |=> $stable(regs_q.addr));
    p_half_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !hi_byte) |=> ($stable(regs_q.cnt[REG_W-1:BYTE_W]) &&
                                  $stable(regs_q.addr[REG_W-1:BYTE_W])));
endmodule

// File: rtl/dma_mask_ctrl.sv
// Module: per-channel mask bits. Master clear sets them all; mask reset
// clears them all; master clear wins. Assumes at most one strobe per cycle.
module dma_mask_ctrl #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_all,
    input  logic              clr_all,
    output logic [NUM_CH-1:0] mask_q
);
    // Mask register: all set on reset or master clear, all clear on mask reset.
    always_ff @(posedge clk) begin
        if (!rst_n || set_all) mask_q <= '1;
        else if (clr_all)      mask_q <= '0;
    end

    p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_all |=> (mask_q == '1));
    p_mask_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && !set_all) |=> (mask_q == '0));
    p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all && !set_all) |=> $stable(mask_q));
endmodule

// File: rtl/dma_chan_regfile.sv
// Module: top of the DMA programming front end. It decodes port offsets,
// drives the shared byte pointer, and muxes read data from the channel
// registers. Assumes strobes last one cycle per access and NUM_CH is a
// power of two, with 2*NUM_CH register ports below the control offsets.
module dma_chan_regfile
    import dma_rf_pkg::*;
#(
    parameter int NUM_CH       = 4,
    parameter int PORT_W       = 4,
    parameter int CLEAR_PORT   = 13,
    parameter int MASKRST_PORT = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [PORT_W-1:0] port_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic [NUM_CH-1:0] chan_mask
);
    localparam int CH_W      = $clog2(NUM_CH);
    localparam int REG_PORTS = 2 * NUM_CH;

    logic              is_reg_port;
    logic [CH_W-1:0]   ch_sel;
    logic              sel_cnt;
    logic              step;
    logic              mclr;
    logic              mrst;
    logic              ptr_hi;
    chan_regs_t        regs [NUM_CH];

    // Offset decode: register-port range, channel field, register select, strobes.
    always_comb begin
        is_reg_port = int'(port_addr) < REG_PORTS;
        ch_sel      = port_addr[CH_W:1];
        sel_cnt     = port_addr[0];
        step        = (wr_en || rd_en) && is_reg_port;
        mclr        = wr_en && (port_addr == PORT_W'(CLEAR_PORT));
        mrst        = wr_en && (port_addr == PORT_W'(MASKRST_PORT));
    end

    dma_byte_ptr u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .clear (mclr),
        .hi_q  (ptr_hi)
    );

    dma_mask_ctrl #(.NUM_CH(NUM_CH)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_all (mclr),
        .clr_all (mrst),
        .mask_q  (chan_mask)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        logic we_ch;
        // Channel write enable: a write to a register port of this channel.
        always_comb we_ch = wr_en && is_reg_port && (ch_sel == CH_W'(i));

        dma_chan_regs u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_stb  (we_ch),
            .sel_cnt (sel_cnt),
            .hi_byte (ptr_hi),
            .wdata   (wr_data),
            .regs_q  (regs[i])
        );
    end

    // Read mux: the byte the pointer selects, or zero off the register range.
    always_comb begin
        logic [REG_W-1:0] word;
        word    = sel_cnt ? regs[ch_sel].cnt : regs[ch_sel].addr;
        rd_data = '0;
        if (rd_en && is_reg_port)
            rd_data = ptr_hi ? word[REG_W-1:BYTE_W] : word[BYTE_W-1:0];
    end

    p_rd_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0));
    p_mrst_keeps_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && port_addr == PORT_W'(MASKRST_PORT)) |=> $stable(ptr_hi));
    p_other_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && !is_reg_port && !mclr && !mrst)
            |=> ($stable(ptr_hi) && $stable(chan_mask)));
endmodule

// File: tb/test_dma_chan_regfile.sv
// Bench: directed corner cases plus seeded random accesses, all checked
// against a behavioural model of registers, byte pointer and masks.
module test_dma_chan_regfile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] port_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [3:0] chan_mask;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_addr [4];
    logic [15:0] m_cnt  [4];
    logic        m_hi;
    logic [3:0]  m_mask;

    always #10 clk = ~clk;

    dma_chan_regfile i_dma_chan_regfile (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .port_addr(port_addr), .wr_data(wr_data),
        .rd_data(rd_data), .chan_mask(chan_mask)
    );

    function automatic logic [7:0] exp_read(input logic [3:0] p);
        logic [15:0] w;
        if (p >= 4'd8) return 8'h00;
        w = p[0] ? m_cnt[p[2:1]] : m_addr[p[2:1]];
        return m_hi ? w[15:8] : w[7:0];
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin m_addr[i] = '0; m_cnt[i] = '0; end
        m_hi = 1'b0; m_mask = 4'hF;
    endtask

    // One access; reads checked in the strobe cycle, mask checked afterwards.
    task automatic access(input string req, input logic rd, input logic wr,
                          input logic [3:0] p, input logic [7:0] d);
        @(negedge clk);
        rd_en = rd; wr_en = wr; port_addr = p; wr_data = d;
        #1;
        if (rd) check8(req, rd_data, exp_read(p));
        if (wr && p < 4'd8) begin
            if (p[0]) begin
                if (m_hi) m_cnt[p[2:1]][15:8] = d; else m_cnt[p[2:1]][7:0] = d;
            end else begin
                if (m_hi) m_addr[p[2:1]][15:8] = d; else m_addr[p[2:1]][7:0] = d;
            end
        end
        if ((rd || wr) && p < 4'd8) m_hi = ~m_hi;
        if (wr && p == 4'hD) begin m_hi = 1'b0; m_mask = 4'hF; end
        if (wr && p == 4'hE) m_mask = 4'h0;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        #1;
        check8(req, {4'h0, chan_mask}, {4'h0, m_mask});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state of masks and of every register byte.
        check8("R1 mask", {4'h0, chan_mask}, 8'h0F);
        for (int p = 0; p < 8; p++) begin
            access("R1 low", 1'b1, 1'b0, 4'(p), 8'h00);
            access("R1 high", 1'b1, 1'b0, 4'(p), 8'h00);
        end
        // R2/R3: load every register, read back low then high.
        for (int p = 0; p < 8; p++) begin
            access("R2 wr", 1'b0, 1'b1, 4'(p), 8'(8'h10 + p));
            access("R2 wr", 1'b0, 1'b1, 4'(p), 8'(8'hA0 + p));
        end
        for (int p = 0; p < 8; p++) begin
            access("R2 R3 rd lo", 1'b1, 1'b0, 4'(p), 8'h00);
            access("R2 R3 rd hi", 1'b1, 1'b0, 4'(p), 8'h00);
        end
        // R4: one write then a read reaches the high byte of another port.
        access("R4 wr", 1'b0, 1'b1, 4'd3, 8'h5C);
        access("R4 mixed rd", 1'b1, 1'b0, 4'd6, 8'h00);
        // R5: read data valid in the strobe cycle.
        access("R5 rd", 1'b1, 1'b0, 4'd2, 8'h00);
        // R6: master clear after one access puts the pointer back to low.
        access("R6 pre", 1'b0, 1'b1, 4'd1, 8'h77);
        access("R6 mclr", 1'b0, 1'b1, 4'hD, 8'h00);
        access("R6 rd lo", 1'b1, 1'b0, 4'd1, 8'h00);
        access("R6 rd hi", 1'b1, 1'b0, 4'd1, 8'h00);
        // R7: mask reset with the pointer high keeps it high.
        access("R7 pre", 1'b1, 1'b0, 4'd0, 8'h00);
        access("R7 mrst", 1'b0, 1'b1, 4'hE, 8'h00);
        access("R7 rd hi", 1'b1, 1'b0, 4'd0, 8'h00);
        // R8: writes to other offsets change nothing.
        for (int p = 8; p < 13; p++) access("R8 ignored", 1'b0, 1'b1, 4'(p), 8'hFF);
        access("R8 ignored", 1'b0, 1'b1, 4'hF, 8'hFF);
        access("R8 rd", 1'b1, 1'b0, 4'd5, 8'h00);
        access("R8 rd", 1'b1, 1'b0, 4'd5, 8'h00);
        // R9: simultaneous read and write on one register port.
        access("R9 both", 1'b1, 1'b1, 4'd7, 8'h3E);
        access("R9 both", 1'b1, 1'b1, 4'd7, 8'hC1);
        access("R9 rd lo", 1'b1, 1'b0, 4'd7, 8'h00);
        access("R9 rd hi", 1'b1, 1'b0, 4'd7, 8'h00);
        // R10: reads off the register range return zero and keep the pointer.
        access("R10 pre", 1'b1, 1'b0, 4'd4, 8'h00);
        access("R10 off", 1'b1, 1'b0, 4'h9, 8'h00);
        access("R10 off", 1'b1, 1'b0, 4'hD, 8'h00);
        access("R10 rd hi", 1'b1, 1'b0, 4'd4, 8'h00);
        // R4: seeded random mix of reads, writes and control strobes.
        for (int n = 0; n < 600; n++) begin
            logic [3:0] p;
            logic rd, wr;
            p  = ($urandom % 4 == 0) ? 4'($urandom) : 4'($urandom % 8);
            rd = 1'($urandom);
            wr = 1'($urandom);
            if (!rd && !wr) rd = 1'b1;
            if (wr && (p == 4'hD || p == 4'hE) && ($urandom % 3 != 0)) wr = 1'b0;
            if (!rd && !wr) rd = 1'b1;
            access("R4 random", rd, wr, p, 8'($urandom));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule